// File: doc/BRIEF.md
# Manchester Word Encoder for a Dual-Redundant Serial Bus

This block turns one 16-bit value into a single word on a 1 Mbit/s command/response serial bus. A word lasts twenty bit times. It starts with a three-bit-time sync shape that is deliberately not valid Manchester code, so a receiver can find the start of a word. Sixteen bi-phase information bits follow, and an odd parity bit closes the word. The sync polarity tells the word type: a command or status word opens high, and a data word opens low.

The sender presents a word, its type and a start strobe. The encoder drives a positive and a negative line for each of its buses, and per-bus enables pick which buses carry the word. A start seen in the final clock of a word chains the next word with no gap. An independent watchdog counts how long the transmitter has been active without a break and silences every drive line for good once the limit is reached; only a reset clears it. A loopback comparator checks each word that the receive path reports back against the word most recently sent.

Top module: `manch_word_tx`

## Requirements
- R1: A word occupies 40 half-bits of CLKS_PER_HALF clocks each. `busy_o` rises on the clock edge that samples an accepted start and stays high for 40*CLKS_PER_HALF cycles per word.
- R2: Half-bits 0 to 5 form the sync. With `is_data_i`=0 (command/status) the positive line is high for half-bits 0 to 2 and low for 3 to 5. With `is_data_i`=1 (data) the pattern is inverted.
- R3: Half-bits 6 to 37 carry `word_i` most significant bit first, two half-bits per bit. A 1 is sent as high then low on the positive line, and a 0 as low then high.
- R4: Half-bits 38 and 39 carry a parity bit P, sent like an information bit. P makes the number of ones in the 16 bits plus P odd.
- R5: A bus whose enable bit `bus_en_i[b]` is 0 has both of its lines low. While `busy_o` is low, every line is low.
- R6: On every bus the positive and negative lines are never high together. While a word is sent on an enabled bus and the watchdog has not tripped, exactly one of the two lines is high.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last half-bit of a word. If no new word is chained, `busy_o` falls in that same cycle.
- R8: A start is ignored while `busy_o` is high, except in the final clock of a word. A start in that clock begins the next word straight away, and `busy_o` stays high.
- R9: Once `busy_o` has been high for WD_LIMIT_CLKS consecutive cycles, `wd_trip_o` rises and stays high until reset, and all drive lines are held low.
- R10: When `rx_valid_i` is high, `loop_fail_o` takes the value (`rx_word_i` != the last word accepted for sending) on the next edge. `loop_fail_o` holds its value between strobes.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (16 MHz by default) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_i | input | 16 | Word to transmit |
| is_data_i | input | 1 | 1 selects data sync, 0 selects command/status sync |
| start_i | input | 1 | Start strobe |
| bus_en_i | input | NUM_BUS | Per-bus drive enables |
| bus_p_o | output | NUM_BUS | Positive drive level for each bus |
| bus_n_o | output | NUM_BUS | Negative drive level for each bus |
| busy_o | output | 1 | Word in progress |
| done_o | output | 1 | One-cycle end-of-word pulse |
| rx_valid_i | input | 1 | Received loopback word is valid |
| rx_word_i | input | 16 | Received loopback word |
| loop_fail_o | output | 1 | Loopback mismatch flag |
| wd_trip_o | output | 1 | Transmit-time limit exceeded |

## Verification
The bench builds the encoder with CLKS_PER_HALF=2 and WD_LIMIT_CLKS=200. A word then lasts 80 clocks, so all-zero, all-one and mixed words, both sync types, enable changes within a word and ignored mid-word starts all fit in a short run. With the start strobe held high, three chained words keep the transmitter active past the 200-cycle limit partway through the third word. This shows the watchdog trip, its persistence and the recovery through reset.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int WORD_W       = 16;
  localparam int SYNC_BITS    = 3;
  localparam int FRAME_BITS   = SYNC_BITS + WORD_W + 1;
  localparam int FRAME_HALVES = 2 * FRAME_BITS;
  localparam int HIDX_W       = $clog2(FRAME_HALVES);

  typedef logic [FRAME_HALVES-1:0] frame_t;

  // half-bit 0 sits in the MSB so the sequencer shifts left
  function automatic frame_t mtx_build_frame(logic [WORD_W-1:0] w, logic is_data);
    frame_t f;
    logic   s;
    logic   par;
    s   = ~is_data;
    par = ~(^w);
    f   = '0;
    for (int i = 0; i < SYNC_BITS; i++) begin
      f[FRAME_HALVES-1-i]           = s;
      f[FRAME_HALVES-1-SYNC_BITS-i] = ~s;
    end
    for (int k = 0; k < WORD_W; k++) begin
      f[FRAME_HALVES-1-2*SYNC_BITS-2*k] = w[WORD_W-1-k];
      f[FRAME_HALVES-2-2*SYNC_BITS-2*k] = ~w[WORD_W-1-k];
    end
    f[1] = par;
    f[0] = ~par;
    return f;
  endfunction
endpackage

// File: rtl/mtx_frame_seq.sv
module mtx_frame_seq
  import mtx_pkg::*;
#(
  parameter int CLKS_PER_HALF = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              is_data_i,
  output logic              busy_o,
  output logic              level_o,
  output logic              done_o,
  output logic              load_o
);
  localparam int CNT_W = (CLKS_PER_HALF > 1) ? $clog2(CLKS_PER_HALF) : 1;
  localparam logic [CNT_W-1:0]  HALF_LAST = CNT_W'(CLKS_PER_HALF - 1);
  localparam logic [HIDX_W-1:0] IDX_LAST  = HIDX_W'(FRAME_HALVES - 1);

  logic              busy_q, done_q;
  frame_t            frame_q;
  logic [CNT_W-1:0]  half_cnt;
  logic [HIDX_W-1:0] half_idx;
  logic              half_end, last_half, load;

  assign half_end  = busy_q && (half_cnt == HALF_LAST);
  assign last_half = half_end && (half_idx == IDX_LAST);
  assign load      = start_i && (!busy_q || last_half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      frame_q  <= '0;
      half_cnt <= '0;
      half_idx <= '0;
    end else begin
      done_q <= last_half;
      if (load) begin
        busy_q   <= 1'b1;
        frame_q  <= mtx_build_frame(word_i, is_data_i);
        half_cnt <= '0;
        half_idx <= '0;
      end else if (last_half) begin
        busy_q   <= 1'b0;
        frame_q  <= '0;
        half_cnt <= '0;
        half_idx <= '0;
      end else if (half_end) begin
        half_cnt <= '0;
        half_idx <= half_idx + 1'b1;
        frame_q  <= {frame_q[FRAME_HALVES-2:0], 1'b0};
      end else if (busy_q) begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign level_o = frame_q[FRAME_HALVES-1];
  assign done_o  = done_q;
  assign load_o  = load;

  AST_HALF_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (half_idx <= IDX_LAST)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7
  AST_BUSY_FALL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q); // R7
  AST_MIDWORD_KEEPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_half) |=> busy_q); // R8
endmodule

// File: rtl/mtx_tx_watchdog.sv
module mtx_tx_watchdog #(
  parameter int WD_LIMIT_CLKS = 12800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic trip_o
);
  localparam int CNT_W = $clog2(WD_LIMIT_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WD_LIMIT_CLKS - 1);

  logic [CNT_W-1:0] act_cnt;
  logic             trip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_cnt <= '0;
      trip_q  <= 1'b0;
    end else if (active_i) begin
      if (act_cnt == CNT_LAST) trip_q <= 1'b1;
      else                     act_cnt <= act_cnt + 1'b1;
    end else begin
      act_cnt <= '0;
    end
  end

  assign trip_o = trip_q;

  AST_TRIP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_q |=> trip_q); // R9
  AST_TRIP_NEEDS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_q) |-> $past(active_i)); // R9
endmodule

// File: rtl/mtx_loopback.sv
module mtx_loopback
  import mtx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              fail_o
);
  logic [WORD_W-1:0] sent_q;
  logic              fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sent_q <= '0;
      fail_q <= 1'b0;
    end else begin
      if (rx_valid_i) fail_q <= (rx_word_i != sent_q);
      if (load_i)     sent_q <= tx_word_i;
    end
  end

  assign fail_o = fail_q;

  AST_FAIL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(fail_q)); // R10
endmodule

// File: rtl/manch_word_tx.sv
module manch_word_tx
  import mtx_pkg::*;
#(
  parameter int CLKS_PER_HALF = 8,
  parameter int WD_LIMIT_CLKS = 12800,
  parameter int NUM_BUS       = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WORD_W-1:0]  word_i,
  input  logic               is_data_i,
  input  logic               start_i,
  input  logic [NUM_BUS-1:0] bus_en_i,
  output logic [NUM_BUS-1:0] bus_p_o,
  output logic [NUM_BUS-1:0] bus_n_o,
  output logic               busy_o,
  output logic               done_o,
  input  logic               rx_valid_i,
  input  logic [WORD_W-1:0]  rx_word_i,
  output logic               loop_fail_o,
  output logic               wd_trip_o
);
  logic busy, level, load, trip;

  mtx_frame_seq #(.CLKS_PER_HALF(CLKS_PER_HALF)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .word_i    (word_i),
    .is_data_i (is_data_i),
    .busy_o    (busy),
    .level_o   (level),
    .done_o    (done_o),
    .load_o    (load)
  );

  mtx_tx_watchdog #(.WD_LIMIT_CLKS(WD_LIMIT_CLKS)) u_wd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (busy),
    .trip_o   (trip)
  );

  mtx_loopback u_loop (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .tx_word_i  (word_i),
    .rx_valid_i (rx_valid_i),
    .rx_word_i  (rx_word_i),
    .fail_o     (loop_fail_o)
  );

  logic drive_ok;
  assign drive_ok = busy && !trip;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    assign bus_p_o[b] = drive_ok && bus_en_i[b] &&  level;
    assign bus_n_o[b] = drive_ok && bus_en_i[b] && !level;

    AST_PAIR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_p_o[b] && bus_n_o[b])); // R6
  end

  assign busy_o    = busy;
  assign wd_trip_o = trip;

  AST_TRIP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_trip_o |-> (bus_p_o == '0 && bus_n_o == '0)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ($countones({bus_p_o, bus_n_o}) == 0)); // R5
endmodule

// File: tb/manch_word_tx_test.sv
module manch_word_tx_test;
  localparam int CPH    = 2;
  localparam int WD     = 200;
  localparam int NB     = 2;
  localparam int HALVES = 40;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [15:0]   word_i = '0;
  logic          is_data_i = 1'b0;
  logic          start_i = 1'b0;
  logic [NB-1:0] bus_en_i = '0;
  logic [NB-1:0] bus_p_o, bus_n_o;
  logic          busy_o, done_o, loop_fail_o, wd_trip_o;
  logic          rx_valid_i = 1'b0;
  logic [15:0]   rx_word_i = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  manch_word_tx #(.CLKS_PER_HALF(CPH), .WD_LIMIT_CLKS(WD), .NUM_BUS(NB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word_i), .is_data_i(is_data_i),
    .start_i(start_i), .bus_en_i(bus_en_i), .bus_p_o(bus_p_o), .bus_n_o(bus_n_o),
    .busy_o(busy_o), .done_o(done_o), .rx_valid_i(rx_valid_i), .rx_word_i(rx_word_i),
    .loop_fail_o(loop_fail_o), .wd_trip_o(wd_trip_o)
  );

  // behavioural reference state
  bit        m_busy, m_done, m_trip, m_fail;
  int        m_half, m_cnt, m_wd;
  bit [15:0] m_sent;
  bit        m_pat[HALVES];

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic build(bit [15:0] w, bit dat);
    int  n = 0;
    bit  s = !dat;
    bit  p = 1'b1;
    for (int i = 0; i < 3; i++) m_pat[n++] = s;
    for (int i = 0; i < 3; i++) m_pat[n++] = !s;
    for (int k = 15; k >= 0; k--) begin
      m_pat[n++] = w[k];
      m_pat[n++] = !w[k];
      p ^= w[k];
    end
    m_pat[n++] = p;
    m_pat[n++] = !p;
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_trip = 0; m_fail = 0;
      m_half = 0; m_cnt = 0; m_wd = 0; m_sent = '0;
    end else begin
      bit last;
      bit ld;
      last = m_busy && m_cnt == CPH-1 && m_half == HALVES-1;
      if (rx_valid_i) m_fail = (rx_word_i != m_sent);
      if (m_busy) begin
        m_wd++;
        if (m_wd >= WD) m_trip = 1;
      end else m_wd = 0;
      m_done = last;
      ld = start_i && (!m_busy || last);
      if (ld) begin
        m_busy = 1; m_half = 0; m_cnt = 0; m_sent = word_i;
        build(word_i, is_data_i);
      end else if (last) begin
        m_busy = 0;
      end else if (m_busy) begin
        if (m_cnt == CPH-1) begin m_cnt = 0; m_half++; end
        else m_cnt++;
      end
    end
    #2;
    chk(rst_ni ? "R1 busy" : "R11 busy", busy_o, m_busy);
    chk(rst_ni ? "R7 done" : "R11 done", done_o, m_done);
    chk("R9 trip", wd_trip_o, m_trip);
    chk("R10 loop_fail", loop_fail_o, m_fail);
    for (int b = 0; b < NB; b++) begin
      string tag;
      bit    ep, en;
      if (m_trip)                       tag = "R9 drive";
      else if (!m_busy || !bus_en_i[b]) tag = "R5 drive";
      else if (m_half < 6)              tag = "R2 sync";
      else if (m_half < 38)             tag = "R3 info";
      else                              tag = "R4 parity";
      ep = m_busy && bus_en_i[b] && !m_trip &&  m_pat[m_half];
      en = m_busy && bus_en_i[b] && !m_trip && !m_pat[m_half];
      chk({tag, " p (R6)"}, bus_p_o[b], ep);
      chk({tag, " n (R6)"}, bus_n_o[b], en);
    end
  end

  task automatic send(bit [15:0] w, bit dat);
    @(negedge clk);
    word_i = w; is_data_i = dat; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic loop_rx(bit [15:0] w);
    @(negedge clk);
    rx_word_i = w; rx_valid_i = 1'b1;
    @(negedge clk);
    rx_valid_i = 1'b0;
    repeat (3) @(negedge clk); // R10 hold
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); // R11 reset values checked each cycle
    rst_ni = 1'b1;
    bus_en_i = 2'b01;
    send(16'hA5C3, 1'b0); wait_idle();          // R2 command sync, R3, R4
    bus_en_i = 2'b10;
    send(16'h0000, 1'b1); wait_idle();          // R2 data sync, R4 parity of zero
    bus_en_i = 2'b11;
    send(16'hFFFF, 1'b1); wait_idle();
    send(16'h8001, 1'b0);                       // R8 ignored mid-word start
    repeat (30) @(negedge clk);
    word_i = 16'h7777; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_idle();
    send(16'h3C5A, 1'b0);                       // R5 enables toggled within word
    repeat (20) @(negedge clk); bus_en_i = 2'b00;
    repeat (20) @(negedge clk); bus_en_i = 2'b10;
    wait_idle();
    bus_en_i = 2'b11;
    loop_rx(16'h3C5A);                          // R10 match
    loop_rx(16'h3C5B);                          // R10 mismatch
    loop_rx(16'h3C5A);
    @(negedge clk);                             // R8 chained words, R9 trip
    word_i = 16'h1234; is_data_i = 1'b1; start_i = 1'b1;
    repeat (260) @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    rst_ni = 1'b0;                              // R11 recovery
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    send(16'h0F0F, 1'b0); wait_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule